// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 31-bit virtual address into a physical address by fetching two words from a sparse page table in memory. It is meant to refill a translation buffer after a miss. A request carries the virtual address and the base of the top-level table. The walker first reads one top-level word, which points to a second-level sub-table. It then reads one leaf word, which holds the physical page number and the page attributes. All reads go through a read port that allows only one read in flight at a time.

The virtual address splits into three fields: a 10-bit top index in bits [30:21], a 9-bit leaf index in bits [20:12], and a 12-bit offset in bits [11:0]. Pages are 4 KB, and the offset passes through untranslated. The table is sparse. If the top-level word is missing, the walk ends after one read and reports a fault. Each response is a one-cycle strobe. It carries the physical address, the access protection code, the cache policy, the dirty and shared flags, and a fault flag.

Top module: `pt_walker`

## Requirements
- R1: After reset, `ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0. While idle with no request, no memory read is issued.
- R2: The first read of a walk goes to `{base_i[31:2],2'b00} + 4*vaddr[30:21]`. The two low bits of `base_i` are ignored.
- R3: When bit 0 of the top-level word is 0, the walk ends with `fault_o`=1 after exactly one memory read, and no leaf read is issued.
- R4: When bit 0 of the top-level word is 1, the second read goes to `{top[31:11],11'b0} + 4*vaddr[20:12]`. Top-level bits [10:1] are ignored.
- R5: When bit 0 of the leaf word is 1, the response has `fault_o`=0 and `paddr_o` = `{leaf[31:12], vaddr[11:0]}`.
- R6: `prot_o` is leaf bits [2:1]. The codes are: 0 = supervisor read-only with no user access, 1 = supervisor read-write with no user access, 2 = read-only for all, 3 = read-write for all.
- R7: `cache_o` is leaf bits [4:3]. The codes are: 1 = uncached, 2 = write-back, 3 = write-through. A stored 0 is reported as 2, the write-back default.
- R8: When bit 0 of the leaf word is 0, the response has `fault_o`=1. `paddr_o`, `prot_o`, `cache_o`, `dirty_o` and `shared_o` are all 0. The same holds for a top-level fault.
- R9: `rsp_valid_o` is high for exactly one cycle per walk. `ready_o` is 0 from the cycle after acceptance until the response. A `req_i` seen while busy is ignored: it causes no extra reads and does not change the response.
- R10: `dirty_o` is leaf bit 5, and `shared_o` is leaf bit 6.
- R11: At most one memory read is outstanding. `mem_req_o` is not raised again until `mem_rvalid_i` has returned the data for the previous read. Data may return in the same cycle as the request or any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a walk; accepted only while `ready_o` is 1 |
| vaddr_i | input | 31 | Virtual address to translate |
| base_i | input | 32 | Byte address of the top-level table |
| ready_o | output | 1 | Walker is idle and can accept a request |
| mem_req_o | output | 1 | One-cycle read request to memory |
| mem_addr_o | output | 32 | Byte address of the word being read |
| mem_rvalid_i | input | 1 | Read data is valid this cycle |
| mem_rdata_i | input | 32 | Read data word |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| fault_o | output | 1 | Translation fault |
| paddr_o | output | 32 | Translated physical address |
| prot_o | output | 2 | Protection code |
| cache_o | output | 2 | Cache policy |
| dirty_o | output | 1 | Dirty flag from the leaf |
| shared_o | output | 1 | Shared flag from the leaf |

## Verification
The hardest case to reach from the ports is a new request arriving while a walk is still in flight, combined with a memory that answers in the same cycle as the request. The bench memory picks a fresh latency of 0 to 3 cycles for every read. One directed walk injects a second request halfway through and then checks the read count and the response contents. Each random walk rebuilds its table entries, mixing absent top-level words, invalid leaves, extreme indices and stray low bits in the base and the top-level word.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_TOP  = 2'd1,
    WS_LEAF = 2'd2,
    WS_DONE = 2'd3
  } walk_state_e;

  localparam logic [1:0] CM_UNCACHED = 2'd1;
  localparam logic [1:0] CM_WBACK    = 2'd2;
  localparam logic [1:0] CM_WTHRU    = 2'd3;
  localparam logic [1:0] CM_DEFAULT  = CM_WBACK;

  // entry word bit positions
  localparam int VLD_BIT    = 0;
  localparam int PROT_LSB   = 1;
  localparam int CACHE_LSB  = 3;
  localparam int DIRTY_BIT  = 5;
  localparam int SHARED_BIT = 6;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int TOP_BITS = 10,
  parameter int BOT_BITS = 9,
  parameter int OFF_BITS = 12,
  localparam int VA_W    = TOP_BITS + BOT_BITS + OFF_BITS
) (
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [ADDR_W-1:2] base_i,
  input  logic [ADDR_W-1:0] sub_base_i,
  input  logic              sel_leaf_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [TOP_BITS-1:0] top_idx;
  logic [BOT_BITS-1:0] bot_idx;
  logic [ADDR_W-1:0]   top_addr, leaf_addr;
  logic [OFF_BITS-1:0] unused_off;

  assign top_idx    = vaddr_i[VA_W-1 -: TOP_BITS];
  assign bot_idx    = vaddr_i[OFF_BITS +: BOT_BITS];
  assign unused_off = vaddr_i[OFF_BITS-1:0];

  // entries are 4-byte words
  assign top_addr  = {base_i, 2'b00} + ADDR_W'({top_idx, 2'b00});
  assign leaf_addr = sub_base_i + ADDR_W'({bot_idx, 2'b00});
  assign addr_o    = sel_leaf_i ? leaf_addr : top_addr;
endmodule

// File: rtl/pt_entry_dec.sv
module pt_entry_dec
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BOT_BITS = 9,
  parameter int OFF_BITS = 12,
  localparam int PPN_W   = ADDR_W - OFF_BITS,
  localparam int SUB_AL  = BOT_BITS + 2
) (
  input  logic [ADDR_W-1:0] word_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] sub_base_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [1:0]        prot_o,
  output logic [1:0]        cache_o,
  output logic              dirty_o,
  output logic              shared_o
);
  logic [1:0] cache_raw;
  logic [SUB_AL-SHARED_BIT-2:0] unused_bits;

  assign valid_o    = word_i[VLD_BIT];
  // sub-table is aligned to its own size
  assign sub_base_o = {word_i[ADDR_W-1:SUB_AL], {SUB_AL{1'b0}}};
  assign ppn_o      = word_i[ADDR_W-1:OFF_BITS];
  assign prot_o     = word_i[PROT_LSB +: 2];
  assign cache_raw  = word_i[CACHE_LSB +: 2];
  assign cache_o    = (cache_raw == 2'd0) ? CM_DEFAULT : cache_raw;
  assign dirty_o    = word_i[DIRTY_BIT];
  assign shared_o   = word_i[SHARED_BIT];
  assign unused_bits = word_i[SUB_AL-1:SHARED_BIT+1];
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        mem_rvalid_i,
  input  logic        top_valid_i,
  output walk_state_e state_o,
  output logic        mem_req_o,
  output logic        accept_o,
  output logic        ld_top_o,
  output logic        ld_leaf_o,
  output logic        top_fault_o
);
  walk_state_e state_q, state_d;
  logic        issued_q;

  wire in_read = (state_q == WS_TOP) || (state_q == WS_LEAF);

  assign state_o     = state_q;
  assign mem_req_o   = in_read && !issued_q;
  assign accept_o    = (state_q == WS_IDLE) && req_i;
  assign ld_top_o    = (state_q == WS_TOP) && mem_rvalid_i && top_valid_i;
  assign top_fault_o = (state_q == WS_TOP) && mem_rvalid_i && !top_valid_i;
  assign ld_leaf_o   = (state_q == WS_LEAF) && mem_rvalid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE: if (req_i) state_d = WS_TOP;
      WS_TOP: begin
        if (ld_top_o)         state_d = WS_LEAF;
        else if (top_fault_o) state_d = WS_DONE;
      end
      WS_LEAF: if (ld_leaf_o) state_d = WS_DONE;
      WS_DONE: state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= WS_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!in_read || mem_rvalid_i) issued_q <= 1'b0;
      else if (mem_req_o)           issued_q <= 1'b1;
    end
  end

  // independent outstanding-read tracker
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pend_q <= 1'b0;
    else if (mem_rvalid_i)              pend_q <= 1'b0;
    else if (mem_req_o)                 pend_q <= 1'b1;
  end

  a_r11_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !mem_req_o);
  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WS_DONE) |=> (state_q == WS_IDLE));
  a_r3_fault_skips_leaf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_fault_o |=> (state_q == WS_DONE) && !mem_req_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TOP_BITS = 10,
  parameter int BOT_BITS = 9,
  parameter int OFF_BITS = 12,
  localparam int VA_W    = TOP_BITS + BOT_BITS + OFF_BITS,
  localparam int PPN_W   = ADDR_W - OFF_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [1:0]        prot_o,
  output logic [1:0]        cache_o,
  output logic              dirty_o,
  output logic              shared_o
);
  walk_state_e state;
  logic accept, ld_top, ld_leaf, top_fault;

  logic [VA_W-1:0]   vaddr_q;
  logic [ADDR_W-1:2] base_q;
  logic [ADDR_W-1:0] sub_base_q;
  logic [1:0]        unused_base;

  logic              dec_valid, dec_dirty, dec_shared;
  logic [ADDR_W-1:0] dec_sub_base;
  logic [PPN_W-1:0]  dec_ppn;
  logic [1:0]        dec_prot, dec_cache;

  logic              fault_q, dirty_q, shared_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [1:0]        prot_q, cache_q;

  assign unused_base = base_i[1:0];

  pt_walk_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .mem_rvalid_i (mem_rvalid_i),
    .top_valid_i  (dec_valid),
    .state_o      (state),
    .mem_req_o    (mem_req_o),
    .accept_o     (accept),
    .ld_top_o     (ld_top),
    .ld_leaf_o    (ld_leaf),
    .top_fault_o  (top_fault)
  );

  pt_addr_gen #(
    .ADDR_W(ADDR_W), .TOP_BITS(TOP_BITS), .BOT_BITS(BOT_BITS), .OFF_BITS(OFF_BITS)
  ) u_addr (
    .vaddr_i    (vaddr_q),
    .base_i     (base_q),
    .sub_base_i (sub_base_q),
    .sel_leaf_i (state == WS_LEAF),
    .addr_o     (mem_addr_o)
  );

  pt_entry_dec #(
    .ADDR_W(ADDR_W), .BOT_BITS(BOT_BITS), .OFF_BITS(OFF_BITS)
  ) u_dec (
    .word_i     (mem_rdata_i),
    .valid_o    (dec_valid),
    .sub_base_o (dec_sub_base),
    .ppn_o      (dec_ppn),
    .prot_o     (dec_prot),
    .cache_o    (dec_cache),
    .dirty_o    (dec_dirty),
    .shared_o   (dec_shared)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q    <= '0;
      base_q     <= '0;
      sub_base_q <= '0;
    end else begin
      if (accept) begin
        vaddr_q <= vaddr_i;
        base_q  <= base_i[ADDR_W-1:2];
      end
      if (ld_top) sub_base_q <= dec_sub_base;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q  <= 1'b0;
      ppn_q    <= '0;
      prot_q   <= '0;
      cache_q  <= '0;
      dirty_q  <= 1'b0;
      shared_q <= 1'b0;
    end else if (top_fault || (ld_leaf && !dec_valid)) begin
      fault_q  <= 1'b1;
      ppn_q    <= '0;
      prot_q   <= '0;
      cache_q  <= '0;
      dirty_q  <= 1'b0;
      shared_q <= 1'b0;
    end else if (ld_leaf) begin
      fault_q  <= 1'b0;
      ppn_q    <= dec_ppn;
      prot_q   <= dec_prot;
      cache_q  <= dec_cache;
      dirty_q  <= dec_dirty;
      shared_q <= dec_shared;
    end
  end

  assign ready_o     = (state == WS_IDLE);
  assign rsp_valid_o = (state == WS_DONE);
  assign fault_o     = fault_q;
  assign paddr_o     = fault_q ? '0 : {ppn_q, vaddr_q[OFF_BITS-1:0]};
  assign prot_o      = prot_q;
  assign cache_o     = cache_q;
  assign dirty_o     = dirty_q;
  assign shared_o    = shared_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o && !rsp_valid_o);
  a_r8_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o) |-> (paddr_o == '0) && (cache_o == 2'd0) && (prot_o == 2'd0));
  a_r7_cache_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !fault_o) |-> (cache_o != 2'd0));
  a_r9_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [30:0] vaddr = '0;
  logic [31:0] base = '0;
  logic        ready, mem_req, mem_rvalid, rsp_valid, fault, dirty, shared;
  logic [31:0] mem_addr, mem_rdata, paddr;
  logic [1:0]  prot, cache;

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(vaddr), .base_i(base),
    .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .fault_o(fault), .paddr_o(paddr),
    .prot_o(prot), .cache_o(cache), .dirty_o(dirty), .shared_o(shared)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mem [bit [31:0]];
  int          rd_cnt = 0;
  logic [31:0] rd_addr [4];
  logic [31:0] pend_addr;
  bit          pend = 0;
  int          lat = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: one read at a time, latency 0..3
  initial mem_rvalid = 1'b0;
  initial mem_rdata = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      pend = 0;
    end else begin
      if (mem_rvalid) mem_rvalid = 1'b0;
      if (mem_req) begin
        if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
        rd_cnt++;
        pend = 1;
        pend_addr = mem_addr;
        lat = $urandom_range(0, 3);
      end else if (pend && lat > 0) lat--;
      if (pend && lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = rd(pend_addr);
        pend = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // expected walk result
  logic [31:0] e_taddr, e_laddr, e_paddr;
  int          e_reads;
  bit          e_fault, e_dirty, e_shared;
  logic [1:0]  e_prot, e_cache;

  task automatic model(input logic [31:0] b, input logic [30:0] va);
    logic [31:0] te, le;
    e_taddr = {b[31:2], 2'b00} + {20'd0, va[30:21], 2'b00};
    te = rd(e_taddr);
    e_paddr = 0; e_prot = 0; e_cache = 0; e_dirty = 0; e_shared = 0;
    e_laddr = 0;
    if (!te[0]) begin
      e_fault = 1; e_reads = 1;
    end else begin
      e_reads = 2;
      e_laddr = {te[31:11], 11'b0} + {21'd0, va[20:12], 2'b00};
      le = rd(e_laddr);
      if (!le[0]) e_fault = 1;
      else begin
        e_fault = 0;
        e_paddr = {le[31:12], va[11:0]};
        e_prot = le[2:1];
        e_cache = (le[4:3] == 2'd0) ? 2'd2 : le[4:3];
        e_dirty = le[5];
        e_shared = le[6];
      end
    end
  endtask

  task automatic build(input logic [31:0] b, input logic [30:0] va, input int kind,
                       input logic [31:0] sub, input logic [9:0] noise, input logic [31:0] leaf);
    logic [31:0] ta, la;
    mem.delete();
    ta = {b[31:2], 2'b00} + {20'd0, va[30:21], 2'b00};
    if (kind == 1) mem[ta] = {sub[31:11], noise, 1'b0};
    if (kind == 2) begin
      mem[ta] = {sub[31:11], noise, 1'b1};
      la = {sub[31:11], 11'b0} + {21'd0, va[20:12], 2'b00};
      mem[la] = leaf;
    end
  endtask

  task automatic walk(input logic [31:0] b, input logic [30:0] va, input bit intrude, input string tag);
    int n;
    model(b, va);
    @(negedge clk);
    rd_cnt = 0;
    req = 1'b1; vaddr = va; base = b;
    @(negedge clk);
    req = 1'b0;
    chk(ready == 1'b0, {"R9 busy ", tag}, ready, 0);
    n = 0;
    while (!rsp_valid && n < 50) begin
      if (intrude && n == 0) begin
        req = 1'b1; vaddr = ~va; base = b + 32'h40;
      end else req = 1'b0;
      @(negedge clk);
      n++;
    end
    req = 1'b0;
    chk(rsp_valid == 1'b1, {"R9 response ", tag}, rsp_valid, 1);
    chk(rd_cnt == e_reads, {(e_reads == 1) ? "R3 reads " : "R11 reads ", tag}, rd_cnt, e_reads);
    chk(rd_addr[0] == e_taddr, {"R2 top addr ", tag}, rd_addr[0], e_taddr);
    if (e_reads == 2 && rd_cnt >= 2) chk(rd_addr[1] == e_laddr, {"R4 leaf addr ", tag}, rd_addr[1], e_laddr);
    chk(fault == e_fault, {"R5 fault ", tag}, fault, e_fault);
    chk(paddr == e_paddr, {e_fault ? "R8 paddr " : "R5 paddr ", tag}, paddr, e_paddr);
    chk(prot == e_prot, {"R6 prot ", tag}, prot, e_prot);
    chk(cache == e_cache, {"R7 cache ", tag}, cache, e_cache);
    chk({dirty, shared} == {e_dirty, e_shared}, {"R10 flags ", tag}, {dirty, shared}, {e_dirty, e_shared});
    @(negedge clk);
    chk(rsp_valid == 1'b0, {"R9 strobe ", tag}, rsp_valid, 0);
    chk(rd_cnt == e_reads, {"R9 no extra read ", tag}, rd_cnt, e_reads);
  endtask

  function automatic logic [31:0] rbase();
    logic [31:0] r = $urandom;
    return {5'h02, r[26:0]};
  endfunction
  function automatic logic [31:0] rsub();
    logic [31:0] r = $urandom;
    return {4'h2, r[27:11], 11'b0};
  endfunction

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 reset", {ready, rsp_valid, mem_req}, 3'b100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd_cnt == 0 && ready == 1'b1, "R1 idle no reads", rd_cnt, 0);

    build(32'h1000_0000, 31'h0, 2, 32'h2000_0800, 10'h0, {20'hABCDE, 5'd0, 2'b00, 2'b01, 2'b00, 1'b1});
    walk(32'h1000_0000, 31'h0, 0, "zero index");
    build(32'h1000_1000, 31'h7FFF_FFFF, 2, 32'h2345_6800, 10'h3FF, {20'h12345, 5'd0, 2'b11, 2'b11, 2'b11, 1'b1});
    walk(32'h1000_1000, 31'h7FFF_FFFF, 0, "max index");
    build(32'h1000_2000, 31'h0123_4567, 2, 32'h2000_1000, 10'h155, {20'h0F0F0, 5'd0, 2'b10, 2'b00, 2'b10, 1'b1});
    walk(32'h1000_2000, 31'h0123_4567, 0, "R7 cache default");
    build(32'h1000_3000, 31'h2AAA_5555, 0, 32'h0, 10'h0, 32'h0);
    walk(32'h1000_3000, 31'h2AAA_5555, 0, "R3 top absent");
    build(32'h1000_4000, 31'h1555_AAAA, 1, 32'h2FFF_F800, 10'h3FE, 32'hFFFF_FFFF);
    walk(32'h1000_4000, 31'h1555_AAAA, 0, "R3 top invalid");
    build(32'h1000_5000, 31'h0765_4321, 2, 32'h2111_1000, 10'h0, 32'hFFFF_FFFE);
    walk(32'h1000_5000, 31'h0765_4321, 0, "R8 leaf invalid");
    build(32'h1000_6000, 31'h3333_3333, 2, 32'h2222_2000, 10'h2A, {20'h55555, 5'd0, 2'b01, 2'b01, 2'b01, 1'b1});
    walk(32'h1000_6000, 31'h3333_3333, 1, "R9 intrude");
    build(32'h1000_7003, 31'h0044_4444, 2, 32'h2444_4000, 10'h0, {20'h77777, 5'd0, 2'b00, 2'b11, 2'b10, 1'b1});
    walk(32'h1000_7003, 31'h0044_4444, 0, "R2 base low bits");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] b, s, lw;
      logic [30:0] va;
      int k;
      b = rbase(); s = rsub(); lw = $urandom; va = 31'($urandom);
      k = $urandom_range(0, 5);
      if (k > 2) k = 2;
      if ($urandom_range(0, 3) != 0) lw[0] = 1'b1;
      build(b, va, k, s, 10'($urandom), lw);
      walk(b, va, ($urandom_range(0, 7) == 0), "random");
    end

    rd_cnt = 0;
    repeat (10) @(negedge clk);
    chk(rd_cnt == 0 && rsp_valid == 1'b0, "R1 idle after walks", rd_cnt, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule